// File: doc/BRIEF.md
# Secure Key-Load Mode Controller

This block sequences access to a battery-backed cipher key store and to the configuration state of a programmable device. It receives one-cycle strobes that a test-access port has already decoded: enter key mode, load one key word, leave key mode and request readback. It also receives a program pulse, a configuration-complete strobe with a flag telling whether the loaded stream was encrypted, and the power-on reset. It produces the key-store write port, the wipe strobes for the key store and the configuration memory, and the permission flags for configuration readback and partial reconfiguration.

Entering key mode always wipes both memories for a fixed number of cycles before any key may be written. Key words are accepted only once that wipe is over and only while key mode lasts. A loaded encrypted design locks readback and partial reconfiguration until a program pulse or a new wipe. Refused key writes set a sticky error, and denied readback requests never reach the memory and return zeros.

Top module: `keyvault_mode_ctrl`

## Requirements
- R1: After power-on reset the controller is awaiting configuration: no write, no wipe strobe, readback and partial reconfiguration not allowed, error flag low, readback data zero.
- R2: An enter-key strobe, taken in any state except wiping, asserts `key_clear_o` and `cfg_clear_o` for exactly CLEAR_CYC cycles (default 8) starting the cycle after the strobe; `key_ready_o` rises in the cycle after the wipe ends, and `key_mode_o` is high during both.
- R3: A load strobe while `key_ready_o` is high and with a valid selector gives `key_we_o` high for one cycle in the next cycle, with `key_addr_o` equal to the selector and `key_wdata_o` equal to the data. Selector encoding: bit 2 is the bank (0 or 1), bits 1:0 the key index, valid values 0 to 2.
- R4: An exit strobe while ready in key mode returns to awaiting configuration in the next cycle.
- R5: A configuration-complete strobe while awaiting configuration with the encrypted flag low sets `rdbk_allow_o` and `partial_allow_o` in the next cycle, even after keys were loaded.
- R6: A configuration-complete strobe with the encrypted flag high leaves both permissions low until a program pulse or a new key-mode wipe.
- R7: A program pulse while awaiting or configured returns to awaiting configuration and removes the lock, without any wipe strobe; a program pulse in key mode is ignored.
- R8: A load strobe while not ready in key mode, or with an invalid key index, writes nothing and sets `load_err_o`, which stays high until the next power-on reset.
- R9: A readback request when allowed drives `rdbk_mem_req_o` in the same cycle and returns the memory data on `rdbk_data_o` in the next cycle; when not allowed, `rdbk_mem_req_o` stays low, and the next cycle shows `rdbk_data_o` zero with `rdbk_denied_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| enter_key_i | input | 1 | Enter key-mode strobe |
| load_key_i | input | 1 | Load one key word strobe |
| exit_key_i | input | 1 | Leave key-mode strobe |
| rdbk_req_i | input | 1 | Configuration readback request |
| prog_i | input | 1 | Program (reconfigure) pulse |
| cfg_done_i | input | 1 | Configuration load complete strobe |
| cfg_enc_i | input | 1 | The completed stream was encrypted |
| key_sel_i | input | 3 | Key selector: bank in bit 2, index in bits 1:0 |
| key_data_i | input | 56 | Key word to store |
| rdbk_mem_data_i | input | 32 | Data from configuration memory |
| key_we_o | output | 1 | Key store write enable |
| key_addr_o | output | 3 | Key store address |
| key_wdata_o | output | 56 | Key store write data |
| key_clear_o | output | 1 | Key store wipe strobe |
| cfg_clear_o | output | 1 | Configuration memory wipe strobe |
| key_mode_o | output | 1 | In key mode (wiping or ready) |
| key_ready_o | output | 1 | Key mode ready for writes |
| rdbk_allow_o | output | 1 | Readback permitted |
| partial_allow_o | output | 1 | Partial reconfiguration permitted |
| rdbk_mem_req_o | output | 1 | Readback request passed to memory |
| rdbk_data_o | output | 32 | Readback result |
| rdbk_denied_o | output | 1 | Readback request was denied |
| load_err_o | output | 1 | Sticky refused-load error |

## Verification
The hardest situation to reach is a load strobe that arrives during the wipe window, since the window opens only after an enter strobe and closes on its own after a fixed count. The bench issues the load in the cycle right after the enter strobe and then counts the remaining wipe cycles, so both the refusal and the exact window length come from one run. The lock that follows an encrypted load is reached by walking the full enter, load, exit and configure sequence from the stimulus table before issuing readback.

// File: rtl/keyvault_pkg.sv
package keyvault_pkg;

    typedef enum logic [1:0] {
        ST_AWAIT = 2'd0,
        ST_CLEAR = 2'd1,
        ST_KEY   = 2'd2,
        ST_RUN   = 2'd3
    } kv_state_e;

endpackage

// File: rtl/keyvault_seq.sv
module keyvault_seq
    import keyvault_pkg::*;
#(
    parameter int CLEAR_CYC = 8,
    localparam int CNT_W = (CLEAR_CYC > 1) ? $clog2(CLEAR_CYC) : 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enter_i,
    input  logic      exit_i,
    input  logic      prog_i,
    input  logic      cfg_done_i,
    input  logic      cfg_enc_i,
    input  logic      load_refused_i,
    output kv_state_e state_o,
    output logic      locked_o,
    output logic      err_o
);

    typedef struct packed {
        kv_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             locked;
        logic             err;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (load_refused_i) begin
            seq_d.err = 1'b1;
        end
        unique case (seq_q.st)
            ST_AWAIT: begin
                if (prog_i) begin
                    seq_d.locked = 1'b0;
                end else if (enter_i) begin
                    seq_d.st     = ST_CLEAR;
                    seq_d.cnt    = CNT_W'(CLEAR_CYC - 1);
                    seq_d.locked = 1'b0;
                end else if (cfg_done_i) begin
                    seq_d.st     = ST_RUN;
                    seq_d.locked = cfg_enc_i;
                end
            end
            ST_RUN: begin
                if (prog_i) begin
                    seq_d.st     = ST_AWAIT;
                    seq_d.locked = 1'b0;
                end else if (enter_i) begin
                    seq_d.st     = ST_CLEAR;
                    seq_d.cnt    = CNT_W'(CLEAR_CYC - 1);
                    seq_d.locked = 1'b0;
                end
            end
            ST_CLEAR: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st = ST_KEY;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_KEY: begin
                if (enter_i) begin
                    seq_d.st  = ST_CLEAR;
                    seq_d.cnt = CNT_W'(CLEAR_CYC - 1);
                end else if (exit_i) begin
                    seq_d.st = ST_AWAIT;
                end
            end
            default: seq_d.st = ST_AWAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_AWAIT, cnt: '0, locked: 1'b0, err: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o  = seq_q.st;
    assign locked_o = seq_q.locked;
    assign err_o    = seq_q.err;

    // R2: key-ready state is only reached through the wipe state
    a_r2_key_via_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_KEY && $past(seq_q.st) != ST_KEY) |-> $past(seq_q.st) == ST_CLEAR);

    // R8: refused-load error never drops without a power-on reset
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.err |=> seq_q.err);

    // R6: the lock exists only while a design is configured
    a_r6_lock_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.locked |-> seq_q.st == ST_RUN);

endmodule

// File: rtl/keyvault_keywr.sv
module keyvault_keywr #(
    parameter int KEY_W         = 56,
    parameter int BANKS         = 2,
    parameter int KEYS_PER_BANK = 3,
    parameter int BANK_W        = 1,
    parameter int IDX_W         = 2,
    localparam int SEL_W = BANK_W + IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             ready_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [KEY_W-1:0] data_i,
    output logic             refused_o,
    output logic             we_o,
    output logic [SEL_W-1:0] addr_o,
    output logic [KEY_W-1:0] wdata_o
);

    typedef struct packed {
        logic             we;
        logic [SEL_W-1:0] addr;
        logic [KEY_W-1:0] data;
    } wr_t;

    wr_t  wr_d, wr_q;
    logic addr_ok;

    always_comb begin
        addr_ok = (int'(sel_i[IDX_W-1:0]) < KEYS_PER_BANK)
               && (int'(sel_i[SEL_W-1:IDX_W]) < BANKS);
        refused_o = load_i && !(ready_i && addr_ok);
        wr_d      = wr_q;
        wr_d.we   = load_i && ready_i && addr_ok;
        if (load_i) begin
            wr_d.addr = sel_i;
            wr_d.data = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= '0;
        end else begin
            wr_q <= wr_d;
        end
    end

    assign we_o    = wr_q.we;
    assign addr_o  = wr_q.addr;
    assign wdata_o = wr_q.data;

    // R3: a write follows a cycle in which key mode was ready
    a_r3_we_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q.we |-> $past(ready_i));

endmodule

// File: rtl/keyvault_rdbk.sv
module keyvault_rdbk #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              allow_i,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic              mem_req_o,
    output logic [DATA_W-1:0] data_o,
    output logic              denied_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              denied;
    } rb_t;

    rb_t rb_d, rb_q;

    always_comb begin
        mem_req_o = req_i && allow_i;
        rb_d.data   = mem_req_o ? mem_data_i : '0;
        rb_d.denied = req_i && !allow_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_q <= '0;
        end else begin
            rb_q <= rb_d;
        end
    end

    assign data_o   = rb_q.data;
    assign denied_o = rb_q.denied;

    // R9: a denied answer carries no data
    a_r9_denied_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rb_q.denied |-> rb_q.data == '0);

    // R9: a denied answer never follows a request that went to memory
    a_r9_denied_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        rb_q.denied |-> !$past(mem_req_o));

endmodule

// File: rtl/keyvault_mode_ctrl.sv
module keyvault_mode_ctrl
    import keyvault_pkg::*;
#(
    parameter int KEY_W         = 56,
    parameter int BANKS         = 2,
    parameter int KEYS_PER_BANK = 3,
    parameter int CLEAR_CYC     = 8,
    parameter int RB_W          = 32,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int IDX_W  = (KEYS_PER_BANK > 1) ? $clog2(KEYS_PER_BANK) : 1,
    localparam int SEL_W  = BANK_W + IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter_key_i,
    input  logic             load_key_i,
    input  logic             exit_key_i,
    input  logic             rdbk_req_i,
    input  logic             prog_i,
    input  logic             cfg_done_i,
    input  logic             cfg_enc_i,
    input  logic [SEL_W-1:0] key_sel_i,
    input  logic [KEY_W-1:0] key_data_i,
    input  logic [RB_W-1:0]  rdbk_mem_data_i,
    output logic             key_we_o,
    output logic [SEL_W-1:0] key_addr_o,
    output logic [KEY_W-1:0] key_wdata_o,
    output logic             key_clear_o,
    output logic             cfg_clear_o,
    output logic             key_mode_o,
    output logic             key_ready_o,
    output logic             rdbk_allow_o,
    output logic             partial_allow_o,
    output logic             rdbk_mem_req_o,
    output logic [RB_W-1:0]  rdbk_data_o,
    output logic             rdbk_denied_o,
    output logic             load_err_o
);

    kv_state_e state;
    logic      locked;
    logic      refused;

    keyvault_seq #(.CLEAR_CYC(CLEAR_CYC)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .enter_i        (enter_key_i),
        .exit_i         (exit_key_i),
        .prog_i         (prog_i),
        .cfg_done_i     (cfg_done_i),
        .cfg_enc_i      (cfg_enc_i),
        .load_refused_i (refused),
        .state_o        (state),
        .locked_o       (locked),
        .err_o          (load_err_o)
    );

    always_comb begin
        key_ready_o     = (state == ST_KEY);
        key_clear_o     = (state == ST_CLEAR);
        cfg_clear_o     = (state == ST_CLEAR);
        key_mode_o      = (state == ST_CLEAR) || (state == ST_KEY);
        rdbk_allow_o    = (state == ST_RUN) && !locked;
        partial_allow_o = (state == ST_RUN) && !locked;
    end

    keyvault_keywr #(
        .KEY_W         (KEY_W),
        .BANKS         (BANKS),
        .KEYS_PER_BANK (KEYS_PER_BANK),
        .BANK_W        (BANK_W),
        .IDX_W         (IDX_W)
    ) u_keywr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_key_i),
        .ready_i   (key_ready_o),
        .sel_i     (key_sel_i),
        .data_i    (key_data_i),
        .refused_o (refused),
        .we_o      (key_we_o),
        .addr_o    (key_addr_o),
        .wdata_o   (key_wdata_o)
    );

    keyvault_rdbk #(.DATA_W(RB_W)) u_rdbk (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (rdbk_req_i),
        .allow_i    (rdbk_allow_o),
        .mem_data_i (rdbk_mem_data_i),
        .mem_req_o  (rdbk_mem_req_o),
        .data_o     (rdbk_data_o),
        .denied_o   (rdbk_denied_o)
    );

    // R2: no key write lands while the stores are being wiped
    a_r2_clear_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        key_clear_o |-> !key_we_o);

    // R6: memory is never asked for data while readback is forbidden
    a_r6_no_req_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !rdbk_allow_o |-> !rdbk_mem_req_o);

endmodule

// File: tb/keyvault_mode_ctrl_bench.sv
`timescale 1ns/1ps
module keyvault_mode_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enter_key_i = 1'b0, load_key_i = 1'b0, exit_key_i = 1'b0;
    logic        rdbk_req_i = 1'b0, prog_i = 1'b0, cfg_done_i = 1'b0, cfg_enc_i = 1'b0;
    logic [2:0]  key_sel_i = '0;
    logic [55:0] key_data_i = '0;
    logic [31:0] rdbk_mem_data_i = '0;
    logic        key_we_o, key_clear_o, cfg_clear_o, key_mode_o, key_ready_o;
    logic        rdbk_allow_o, partial_allow_o, rdbk_mem_req_o, rdbk_denied_o, load_err_o;
    logic [2:0]  key_addr_o;
    logic [55:0] key_wdata_o;
    logic [31:0] rdbk_data_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    keyvault_mode_ctrl u_keyvault_mode_ctrl (.*);

    // stim {enter,load,exit,rdreq,prog,cfg_done,enc}, sel, wait, exp {we,mode,ready,rd,part,err}
    localparam int NV = 14;
    localparam logic [19:0] VEC [NV] = '{
        {7'b1000000, 3'd0, 4'd7, 6'b010000},  // R2 still wiping after 7 extra cycles
        {7'b0000000, 3'd0, 4'd0, 6'b011000},  // R2 ready after CLEAR_CYC cycles
        {7'b0100000, 3'd0, 4'd0, 6'b111000},  // R3 bank0 key0
        {7'b0100000, 3'd5, 4'd0, 6'b111000},  // R3 bank1 key1
        {7'b0010000, 3'd0, 4'd0, 6'b000000},  // R4 exit
        {7'b0000010, 3'd0, 4'd0, 6'b000110},  // R5 plain config with keys present
        {7'b0000100, 3'd0, 4'd0, 6'b000000},  // R7 program
        {7'b0000011, 3'd0, 4'd0, 6'b000000},  // R6 encrypted config locks
        {7'b0000100, 3'd0, 4'd0, 6'b000000},  // R7 program lifts lock
        {7'b0000011, 3'd0, 4'd0, 6'b000000},  // R6 locked again
        {7'b1000000, 3'd0, 4'd8, 6'b011000},  // R6 wipe ends lock, key mode ready
        {7'b0010000, 3'd0, 4'd0, 6'b000000},  // R4 exit
        {7'b0100010, 3'd0, 4'd0, 6'b000111},  // R8 load outside key mode, with plain config
        {7'b0000100, 3'd0, 4'd0, 6'b000001}   // R8 error sticky across program
    };

    task automatic check(input logic ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {enter_key_i, load_key_i, exit_key_i, rdbk_req_i, prog_i, cfg_done_i, cfg_enc_i} = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic clear_inputs();
        {enter_key_i, load_key_i, exit_key_i, rdbk_req_i, prog_i, cfg_done_i, cfg_enc_i} = '0;
    endtask

    function automatic logic [5:0] flags();
        return {key_we_o, key_mode_o, key_ready_o, rdbk_allow_o, partial_allow_o, load_err_o};
    endfunction

    initial begin
        #(8ns * 200000);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        check(flags() == 6'b0 && !key_clear_o && !cfg_clear_o, "R1 flags",
              {key_clear_o, flags()}, 0);
        check(rdbk_data_o == '0 && !rdbk_denied_o && !rdbk_mem_req_o, "R1 readback",
              {rdbk_denied_o, rdbk_data_o}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [19:0] v;
            v = VEC[i];
            {enter_key_i, load_key_i, exit_key_i, rdbk_req_i, prog_i, cfg_done_i, cfg_enc_i} = v[19:13];
            key_sel_i  = v[12:10];
            key_data_i = 56'hA1B2C3D4E5F607 ^ 56'(v[12:10]);
            @(negedge clk);
            clear_inputs();
            repeat (int'(v[9:6])) @(negedge clk);
            check(flags() == v[5:0], $sformatf("table row %0d flags", i), flags(), v[5:0]);
            if (v[5]) begin
                check(key_addr_o == v[12:10] &&
                      key_wdata_o == (56'hA1B2C3D4E5F607 ^ 56'(v[12:10])),
                      "R3 write address and data", {key_addr_o, key_wdata_o},
                      {v[12:10], 56'hA1B2C3D4E5F607 ^ 56'(v[12:10])});
            end
        end

        // R1 / R8: power-on reset clears the sticky error
        do_reset();
        @(negedge clk);
        check(load_err_o == 1'b0, "R8 error cleared by reset", load_err_o, 0);

        // R8: invalid key index in ready key mode
        enter_key_i = 1'b1;
        @(negedge clk);
        clear_inputs();
        repeat (8) @(negedge clk);
        load_key_i = 1'b1;
        key_sel_i  = 3'd3;
        @(negedge clk);
        clear_inputs();
        check(!key_we_o && load_err_o, "R8 invalid index refused", {key_we_o, load_err_o}, 2'b01);

        // R2 / R8: load during wipe, and wipe length
        do_reset();
        enter_key_i = 1'b1;
        @(negedge clk);
        clear_inputs();
        check(key_clear_o && cfg_clear_o && key_mode_o && !key_ready_o, "R2 wipe strobes",
              {key_clear_o, cfg_clear_o, key_mode_o, key_ready_o}, 4'b1110);
        load_key_i = 1'b1;
        key_sel_i  = 3'd0;
        @(negedge clk);
        clear_inputs();
        check(!key_we_o && load_err_o, "R8 load during wipe refused",
              {key_we_o, load_err_o}, 2'b01);
        begin
            int n;
            n = 2;
            while (key_clear_o && n < 100) begin
                @(negedge clk);
                if (key_clear_o) n++;
            end
            check(n == 8, "R2 wipe length", n, 8);
        end
        check(key_ready_o && !cfg_clear_o, "R2 ready after wipe", key_ready_o, 1);

        // R7: program ignored in key mode
        prog_i = 1'b1;
        @(negedge clk);
        clear_inputs();
        check(key_ready_o && !key_clear_o, "R7 program ignored in key mode",
              {key_ready_o, key_clear_o}, 2'b10);

        // R3: bank1 key2 write
        load_key_i = 1'b1;
        key_sel_i  = 3'd6;
        key_data_i = 56'h0F1E2D3C4B5A69;
        @(negedge clk);
        clear_inputs();
        check(key_we_o && key_addr_o == 3'd6 && key_wdata_o == 56'h0F1E2D3C4B5A69,
              "R3 bank1 key2", {key_we_o, key_addr_o, key_wdata_o},
              {1'b1, 3'd6, 56'h0F1E2D3C4B5A69});
        @(negedge clk);
        check(!key_we_o, "R3 single-cycle write", key_we_o, 0);

        // R6 / R9: encrypted design denies readback
        exit_key_i = 1'b1;
        @(negedge clk);
        clear_inputs();
        cfg_done_i = 1'b1;
        cfg_enc_i  = 1'b1;
        @(negedge clk);
        clear_inputs();
        rdbk_mem_data_i = 32'hDEADBEEF;
        rdbk_req_i = 1'b1;
        #1;
        check(!rdbk_mem_req_o, "R9 denied request held back", rdbk_mem_req_o, 0);
        @(negedge clk);
        clear_inputs();
        check(rdbk_denied_o && rdbk_data_o == '0 && !partial_allow_o, "R6 R9 denied readback",
              {rdbk_denied_o, rdbk_data_o}, {1'b1, 32'h0});

        // R7 / R9: program, plain design, readback allowed
        prog_i = 1'b1;
        @(negedge clk);
        clear_inputs();
        check(!key_clear_o && !rdbk_allow_o, "R7 program no wipe", {key_clear_o, rdbk_allow_o}, 0);
        cfg_done_i = 1'b1;
        @(negedge clk);
        clear_inputs();
        rdbk_req_i = 1'b1;
        #1;
        check(rdbk_mem_req_o, "R9 request forwarded", rdbk_mem_req_o, 1);
        @(negedge clk);
        clear_inputs();
        check(!rdbk_denied_o && rdbk_data_o == 32'hDEADBEEF, "R9 readback data",
              {rdbk_denied_o, rdbk_data_o}, {1'b0, 32'hDEADBEEF});
        @(negedge clk);
        check(rdbk_data_o == '0, "R9 data returns to zero", rdbk_data_o, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule